// File: doc/BRIEF.md
# Receive Statistics Counters with Half-Scale Interrupts

This block keeps three receive-side statistics counters for an Ethernet MAC. It counts good unicast frames, frames with an alignment error and frames with a CRC error. Each event arrives as a one-cycle pulse from the frame checker. Each counter is `CNT_W` bits wide, starts at zero, wraps from all-ones back to zero, and is never cleared by a read.

When a counter's most significant bit goes from 0 to 1, the block latches a status flag in a 32-bit interrupt status word. Software clears that flag by reading the counter that raised it, and the read must include byte lane 0. A mask word decides which flags reach the single `irq` output. All registers are read and written over a simple word bus with address, byte enables and separate read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `rx_stat_counters`

## Requirements
- R1: After reset every counter, the status word, the mask word, `irq` and `bus_rdata` are zero.
- R2: A pulse on `ev_crc`, `ev_align` or `ev_ucast` adds one to its own counter. The counters are read at offsets 0x194 (CRC error), 0x198 (alignment error) and 0x1C4 (good unicast). Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: A counter at all-ones that receives a pulse wraps to zero.
- R4: A status flag sets when its counter's MSB changes from 0 to 1. The status word is read at offset 0x104, with bit 17 for good unicast, bit 6 for alignment error and bit 5 for CRC error. All other bits read as zero.
- R5: A read of a counter with `bus_be[0]`=1 clears that counter's flag. A read of the counter with `bus_be[0]`=0 leaves the flag set.
- R6: Writes to the status word at 0x104 have no effect on it.
- R7: If a flag's set condition and its clearing read happen in the same cycle, the flag ends up set.
- R8: After a flag is cleared, it does not set again while its counter's MSB stays 1.
- R9: The mask word at offset 0x10C is written with byte enables and uses the same bit positions as the status word. A mask bit of 1 blocks that flag. `irq` is the OR of the unmasked flags, and unimplemented mask bits read as zero.
- R10: An event pulse in the same cycle as a read of its counter is still counted, and the read returns the value from before the increment.
- R11: Reading a counter does not change its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ucast | input | 1 | Good unicast frame pulse |
| ev_align | input | 1 | Alignment error frame pulse |
| ev_crc | input | 1 | CRC error frame pulse |
| bus_addr | input | AW | Byte address of the register word |
| bus_be | input | 4 | Byte lane enables |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | OR of unmasked status flags |

## Verification
The bench builds the block with `CNT_W`=8, so the MSB sets after 128 pulses and the counter wraps after 256. This puts half-scale detection, the flag-clearing corners and wrap-around within a few hundred cycles. The other parameters keep their default values, so the bus offsets and flag bit positions are the ones listed in the requirements.

// File: rtl/rx_stat_counters.sv
module rx_stat_counters #(
  parameter int CNT_W = 32,
  parameter int AW = 12,
  parameter logic [AW-1:0] A_STAT  = 12'h104,
  parameter logic [AW-1:0] A_MASK  = 12'h10C,
  parameter logic [AW-1:0] A_CRC   = 12'h194,
  parameter logic [AW-1:0] A_ALIGN = 12'h198,
  parameter logic [AW-1:0] A_UCAST = 12'h1C4,
  parameter int POS_CRC   = 5,
  parameter int POS_ALIGN = 6,
  parameter int POS_UCAST = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_ucast,
  input  logic          ev_align,
  input  logic          ev_crc,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int N = 3;
  localparam logic [AW-1:0] ADDR [N] = '{A_CRC, A_ALIGN, A_UCAST};
  localparam int POS [N] = '{POS_CRC, POS_ALIGN, POS_UCAST};
  localparam logic [CNT_W-1:0] PRE_MSB = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [31:0] IMPL = (32'd1 << POS_CRC) | (32'd1 << POS_ALIGN) | (32'd1 << POS_UCAST);

  logic [N-1:0]            ev;
  logic [N-1:0][CNT_W-1:0] cnt;
  logic [N-1:0]            flag;
  logic [31:0]             stat_word, mask_q, rd_next;

  assign ev = {ev_ucast, ev_align, ev_crc};

  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic clr_hit, msb_up;
    assign clr_hit = bus_rd && bus_be[0] && (bus_addr == ADDR[g]);
    assign msb_up  = ev[g] && (cnt[g] == PRE_MSB);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g]  <= '0;
        flag[g] <= 1'b0;
      end else begin
        if (ev[g]) cnt[g] <= cnt[g] + 1'b1;
        if (msb_up) flag[g] <= 1'b1;
        else if (clr_hit) flag[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < N; i++) stat_word[POS[i]] = flag[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (bus_wr && bus_addr == A_MASK)
      for (int b = 0; b < 4; b++)
        if (bus_be[b]) mask_q[8*b +: 8] <= bus_wdata[8*b +: 8] & IMPL[8*b +: 8];
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == A_STAT) rd_next = stat_word;
    if (bus_addr == A_MASK) rd_next = mask_q;
    for (int i = 0; i < N; i++)
      if (bus_addr == ADDR[i]) rd_next = 32'(cnt[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign irq = |(stat_word & ~mask_q);
endmodule

module rx_stat_counters_chk #(
  parameter int CNT_W = 32,
  parameter int AW = 12,
  parameter logic [AW-1:0] A_CRC   = 12'h194,
  parameter logic [AW-1:0] A_ALIGN = 12'h198,
  parameter logic [AW-1:0] A_UCAST = 12'h1C4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            ev,
  input logic                  bus_rd,
  input logic [3:0]            bus_be,
  input logic [AW-1:0]         bus_addr,
  input logic [2:0][CNT_W-1:0] cnt,
  input logic [2:0]            flag,
  input logic                  irq
);
  localparam logic [AW-1:0] ADDR [3] = '{A_CRC, A_ALIGN, A_UCAST};
  localparam logic [CNT_W-1:0] PRE_MSB = {1'b0, {(CNT_W-1){1'b1}}};

  for (genvar g = 0; g < 3; g++) begin : g_a
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev[g] |=> cnt[g] == CNT_W'($past(cnt[g]) + 1'b1));
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[g] && cnt[g] == '1) |=> cnt[g] == '0);
    assert_set_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[g]) |-> (cnt[g][CNT_W-1] && !$past(cnt[g][CNT_W-1])));
    assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_be[0] && bus_addr == ADDR[g] && !(ev[g] && cnt[g] == PRE_MSB)) |=> !flag[g]);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[g] && cnt[g] == PRE_MSB) |=> flag[g]);
    assert_read_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ev[g] |=> $stable(cnt[g]));
  end

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == 3'b000) |-> !irq);
endmodule

bind rx_stat_counters rx_stat_counters_chk #(
  .CNT_W(CNT_W), .AW(AW), .A_CRC(A_CRC), .A_ALIGN(A_ALIGN), .A_UCAST(A_UCAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev), .bus_rd(bus_rd), .bus_be(bus_be),
  .bus_addr(bus_addr), .cnt(cnt), .flag(flag), .irq(irq)
);

// File: tb/test_rx_stat_counters.sv
module test_rx_stat_counters;
  localparam int W = 8;
  localparam logic [11:0] A_STAT = 12'h104, A_MASK = 12'h10C,
                          A_CRC = 12'h194, A_ALIGN = 12'h198, A_UCAST = 12'h1C4;

  logic clk = 0, rst_n = 0;
  logic ev_ucast = 0, ev_align = 0, ev_crc = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  rx_stat_counters #(.CNT_W(W)) i_rx_stat_counters (
    .clk(clk), .rst_n(rst_n), .ev_ucast(ev_ucast), .ev_align(ev_align), .ev_crc(ev_crc),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulses(logic [2:0] sel, int n);
    @(negedge clk) {ev_ucast, ev_align, ev_crc} = sel;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) {ev_ucast, ev_align, ev_crc} = 3'b000;
  endtask

  task automatic rd(logic [11:0] a, logic [3:0] be, output logic [31:0] d);
    @(negedge clk) begin bus_rd = 1; bus_addr = a; bus_be = be; end
    @(negedge clk) begin bus_rd = 0; bus_be = 0; d = bus_rdata; end
  endtask

  task automatic wr(logic [11:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk) begin bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d; end
    @(negedge clk) begin bus_wr = 0; bus_be = 0; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 rdata", bus_rdata, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(A_CRC, 4'hF, d);   check("R1 crc", d, 0);
    rd(A_UCAST, 4'hF, d); check("R1 ucast", d, 0);
    rd(A_STAT, 4'hF, d);  check("R1 stat", d, 0);
    rd(A_MASK, 4'hF, d);  check("R1 mask", d, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    do_reset();
    pulses(3'b001, 5); pulses(3'b010, 3); pulses(3'b100, 7);
    rd(A_CRC, 4'hF, d);   check("R2 crc", d, 5);
    rd(A_ALIGN, 4'hF, d); check("R2 align", d, 3);
    rd(A_UCAST, 4'hF, d); check("R2 ucast", d, 7);
    rd(A_UCAST, 4'hF, d); check("R11 reread", d, 7);
    pulses(3'b111, 2);
    rd(A_CRC, 4'hF, d);   check("R2 joint", d, 7);
  endtask

  task automatic t_half_clear();
    logic [31:0] d;
    do_reset();
    pulses(3'b001, 127);
    rd(A_STAT, 4'hF, d); check("R4 below half", d, 0);
    pulses(3'b001, 1);
    rd(A_STAT, 4'hF, d); check("R4 crc bit5", d, 32'h20);
    check("R9 irq on", {31'd0, irq}, 1);
    rd(A_CRC, 4'hE, d);  check("R11 value", d, 128);
    rd(A_STAT, 4'hF, d); check("R5 upper lanes keep", d, 32'h20);
    rd(A_CRC, 4'h1, d);
    rd(A_STAT, 4'hF, d); check("R5 lane0 clears", d, 0);
    check("R5 irq off", {31'd0, irq}, 0);
    pulses(3'b001, 10);
    rd(A_STAT, 4'hF, d); check("R8 no re-set", d, 0);
    pulses(3'b010, 128);
    rd(A_STAT, 4'hF, d); check("R4 align bit6", d, 32'h40);
  endtask

  task automatic t_stat_write();
    logic [31:0] d;
    do_reset();
    pulses(3'b100, 128);
    wr(A_STAT, 4'hF, 32'h0);
    rd(A_STAT, 4'hF, d); check("R6 write zero", d, 32'h20000);
    wr(A_STAT, 4'hF, 32'hFFFF_FFFF);
    rd(A_STAT, 4'hF, d); check("R6 write ones", d, 32'h20000);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    do_reset();
    pulses(3'b100, 127);
    @(negedge clk) begin ev_ucast = 1; bus_rd = 1; bus_addr = A_UCAST; bus_be = 4'h1; end
    @(negedge clk) begin ev_ucast = 0; bus_rd = 0; bus_be = 0; d = bus_rdata; end
    check("R10 pre-increment", d, 127);
    rd(A_STAT, 4'hF, d);  check("R7 set wins", d, 32'h20000);
    rd(A_UCAST, 4'hE, d); check("R10 counted", d, 128);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    pulses(3'b010, 128);
    check("R9 irq unmasked", {31'd0, irq}, 1);
    wr(A_MASK, 4'hF, 32'hFFFF_FFFF);
    check("R9 irq masked", {31'd0, irq}, 0);
    rd(A_MASK, 4'hF, d); check("R9 mask impl bits", d, 32'h20060);
    rd(A_STAT, 4'hF, d); check("R9 stat kept", d, 32'h40);
    wr(A_MASK, 4'h1, 32'h0);
    check("R9 irq lane0 unmask", {31'd0, irq}, 1);
    rd(A_MASK, 4'hF, d); check("R9 byte enables", d, 32'h20000);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    do_reset();
    pulses(3'b001, 255);
    rd(A_CRC, 4'hF, d); check("R3 all ones", d, 255);
    pulses(3'b001, 1);
    rd(A_CRC, 4'hF, d); check("R3 wrap", d, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_half_clear();
    t_stat_write();
    t_collision();
    t_mask();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule